// File: doc/BRIEF.md
# Random Uniform 3-SAT Instance Generator

This block builds a random 3-SAT problem of a requested size and streams it, one clause at a time, into a clause memory that sits outside the block. A clause is three literal indices over 2N literals, where literal 2v is variable v in true form and literal 2v+1 is variable v complemented. After `start`, the generator draws three different literals with equal probability from the 2N in play and sorts them ascending. It then discards any candidate that names one variable in both polarities, or that repeats a clause already produced in this run. Rejected candidates are replaced by fresh draws until the requested number of clauses has been produced.

Random numbers come from a seeded linear-feedback shift register that takes several steps per cycle. Each draw is masked to the smallest power-of-two range that covers 2N, and values at or above 2N are thrown away, so every literal stays equally likely. The duplicate check walks the clauses accepted so far, comparing one stored clause per cycle against the sorted candidate. The same seed with the same sizes always yields the same instance.

Clauses leave on a valid/ready write port. Once `wr_valid` is high it stays high, and the index and literals hold still, until the cycle in which `wr_ready` is also high. The sink may hold `wr_ready` low for as long as it likes. The generator makes no progress while stalled, and no clause is lost or repeated. `done` is a plain level.

Top module: `sat_gen_top`

## Requirements
- R1: After reset `done` and `wr_valid` are low. A `start` seen while idle or finished latches the clause count, variable count and seed, and for a nonzero clause count `done` is low in the next cycle.
- R2: Every clause written has literal indices strictly ascending (`wr_lit0 < wr_lit1 < wr_lit2`), and all of them are below 2N.
- R3: No clause written holds both literals of one variable, where literal 2v is v true and 2v+1 is v complemented (two literals clash when they agree in all bits above bit 0).
- R4: Within one run no clause is written twice. When M equals the number of valid clauses, 8·N·(N−1)·(N−2)/6, every valid clause therefore appears once.
- R5: A run writes exactly min(M, MAX_CLAUSES) clauses, with `wr_index` taking the values 0, 1, 2 … in order, one per handshake.
- R6: While `wr_valid` is high and `wr_ready` is low, the next cycle still has `wr_valid` high, with index and literals unchanged.
- R7: `done` rises in the cycle after the last clause's handshake and then holds, with `wr_valid` low, until the next `start`. A start with M = 0 raises `done` in the next cycle.
- R8: The same seed, M and N give the same clause sequence. A zero seed is replaced by a fixed nonzero value, so the run still completes.
- R9: A `start` pulse while a run is in progress is ignored. The run keeps its original M and its index sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (accepted only while idle or finished) |
| cfg_clauses | input | CNT_W (7) | Number of clauses M, clamped to MAX_CLAUSES |
| cfg_vars | input | VAR_W (6) | Number of variables N (3 to MAX_VARS) |
| seed | input | 32 | Random seed; zero maps to a fixed nonzero value |
| wr_valid | output | 1 | Clause write is offered |
| wr_ready | input | 1 | Clause memory accepts the write |
| wr_index | output | IDX_W (6) | Clause slot being written |
| wr_lit0 | output | LIT_W (6) | Smallest literal index |
| wr_lit1 | output | LIT_W (6) | Middle literal index |
| wr_lit2 | output | LIT_W (6) | Largest literal index |
| done | output | 1 | All M clauses have been written |

## Verification
Two events can fall in the same cycle. One is a stalled write being released. The other is that write being the final clause, which also ends the run. The bench throttles `wr_ready` with several periodic patterns, so the last clause often waits through stalls before its handshake. It then checks that `done` is high, with `wr_valid` low, exactly one cycle after that handshake. A `start` pulse is also injected in the middle of a run, while writes are stalling, to confirm it neither resets the index sequence nor shortens the run.

// File: rtl/sat_gen_pkg.sv
package sat_gen_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DRAW,
    ST_SORT,
    ST_SCAN,
    ST_EMIT,
    ST_DONE
  } gen_state_e;

  localparam int unsigned LFSR_W        = 32;
  localparam logic [31:0] LFSR_TAPS     = 32'h8020_0003;
  localparam logic [31:0] SEED_FALLBACK = 32'h1D87_2B41;

endpackage

// File: rtl/sat_gen_lfsr.sv
module sat_gen_lfsr
  import sat_gen_pkg::*;
#(
  parameter int unsigned STEPS = 8,
  parameter int unsigned OUT_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [LFSR_W-1:0] seed,
  input  logic              advance,
  output logic [OUT_W-1:0]  rnd
);

  logic [LFSR_W-1:0] state_q;
  logic [LFSR_W-1:0] chain [STEPS+1];

  function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
    logic [LFSR_W-1:0] n;
    n = s >> 1;
    if (s[0]) n = n ^ LFSR_TAPS;
    return n;
  endfunction

  assign chain[0] = state_q;

  for (genvar g = 0; g < STEPS; g++) begin : g_step
    assign chain[g+1] = lfsr_step(chain[g]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEED_FALLBACK;
    end else if (load) begin
      state_q <= (seed == '0) ? SEED_FALLBACK : seed;
    end else if (advance) begin
      state_q <= chain[STEPS];
    end
  end

  assign rnd = state_q[OUT_W-1:0];

  AST_LFSR_ALIVE: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0) else $error("lfsr reached zero"); // R8

endmodule

// File: rtl/sat_gen_sort3.sv
module sat_gen_sort3 #(
  parameter int unsigned LIT_W = 6
) (
  input  logic [LIT_W-1:0] in_a,
  input  logic [LIT_W-1:0] in_b,
  input  logic [LIT_W-1:0] in_c,
  output logic [LIT_W-1:0] lo,
  output logic [LIT_W-1:0] mid,
  output logic [LIT_W-1:0] hi,
  output logic             clash
);

  logic [LIT_W-1:0] ab_lo, ab_hi;

  always_comb begin
    if (in_a < in_b) begin
      ab_lo = in_a;
      ab_hi = in_b;
    end else begin
      ab_lo = in_b;
      ab_hi = in_a;
    end
    if (in_c < ab_lo) begin
      lo  = in_c;
      mid = ab_lo;
      hi  = ab_hi;
    end else if (in_c < ab_hi) begin
      lo  = ab_lo;
      mid = in_c;
      hi  = ab_hi;
    end else begin
      lo  = ab_lo;
      mid = ab_hi;
      hi  = in_c;
    end
    // sorted distinct literals of one variable are always neighbours
    clash = (lo[LIT_W-1:1] == mid[LIT_W-1:1]) || (mid[LIT_W-1:1] == hi[LIT_W-1:1]);
  end

endmodule

// File: rtl/sat_gen_store.sv
module sat_gen_store #(
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned DATA_W = 18,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              scan_go,
  input  logic [DATA_W-1:0] scan_key,
  input  logic [CNT_W-1:0]  fill,
  output logic              scan_hit,
  output logic              scan_miss
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [CNT_W-1:0]  ptr_q;
  logic              busy_q;
  logic              at_end;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign at_end    = (ptr_q == fill);
  assign scan_miss = busy_q && at_end;
  assign scan_hit  = busy_q && !at_end && (mem[ptr_q[IDX_W-1:0]] == scan_key);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ptr_q  <= '0;
    end else if (scan_go) begin
      busy_q <= 1'b1;
      ptr_q  <= '0;
    end else if (busy_q) begin
      if (scan_hit || scan_miss) busy_q <= 1'b0;
      else                       ptr_q  <= ptr_q + 1'b1;
    end
  end

  AST_SCAN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (ptr_q <= fill)) else $error("scan past fill level"); // R4
  AST_SCAN_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !wr_en) else $error("write during duplicate scan"); // R4

endmodule

// File: rtl/sat_gen_top.sv
module sat_gen_top
  import sat_gen_pkg::*;
#(
  parameter int unsigned MAX_CLAUSES = 64,
  parameter int unsigned MAX_VARS    = 32,
  parameter int unsigned LFSR_STEPS  = 8,
  localparam int unsigned IDX_W = $clog2(MAX_CLAUSES),
  localparam int unsigned CNT_W = $clog2(MAX_CLAUSES + 1),
  localparam int unsigned VAR_W = $clog2(MAX_VARS + 1),
  localparam int unsigned LIT_W = $clog2(2 * MAX_VARS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  cfg_clauses,
  input  logic [VAR_W-1:0]  cfg_vars,
  input  logic [31:0]       seed,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [IDX_W-1:0]  wr_index,
  output logic [LIT_W-1:0]  wr_lit0,
  output logic [LIT_W-1:0]  wr_lit1,
  output logic [LIT_W-1:0]  wr_lit2,
  output logic              done
);

  localparam int unsigned TWO_W = VAR_W + 1;
  localparam int unsigned CL_W  = 3 * LIT_W;

  gen_state_e        state_q;
  logic [CNT_W-1:0]  m_q, count_q, m_clamped;
  logic [TWO_W-1:0]  two_n_q, cfg_two_n;
  logic [LIT_W-1:0]  mask_q, mask_next;
  logic [1:0]        slot_q;
  logic [LIT_W-1:0]  raw_q [3];
  logic [CL_W-1:0]   cand_q;
  logic [LIT_W-1:0]  rnd, draw;
  logic              draw_ok;
  logic [LIT_W-1:0]  s_lo, s_mid, s_hi;
  logic              s_clash;
  logic              scan_go, scan_hit, scan_miss;
  logic              accept, take_start;

  // configuration decode
  assign cfg_two_n  = {cfg_vars, 1'b0};
  assign m_clamped  = (cfg_clauses > CNT_W'(MAX_CLAUSES)) ? CNT_W'(MAX_CLAUSES) : cfg_clauses;
  assign take_start = start && (state_q == ST_IDLE || state_q == ST_DONE);

  always_comb begin
    mask_next = '0;
    for (int i = 0; i < LIT_W; i++) begin
      if (TWO_W'(mask_next) + TWO_W'(1) < cfg_two_n)
        mask_next = {mask_next[LIT_W-2:0], 1'b1};
    end
  end

  sat_gen_lfsr #(.STEPS(LFSR_STEPS), .OUT_W(LIT_W)) i_lfsr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (take_start),
    .seed    (seed),
    .advance (state_q == ST_DRAW),
    .rnd     (rnd)
  );

  // literal draw with rejection of out-of-range and repeated values
  assign draw = rnd & mask_q;
  always_comb begin
    draw_ok = (TWO_W'(draw) < two_n_q);
    if (slot_q >= 2'd1 && draw == raw_q[0]) draw_ok = 1'b0;
    if (slot_q == 2'd2 && draw == raw_q[1]) draw_ok = 1'b0;
  end

  sat_gen_sort3 #(.LIT_W(LIT_W)) i_sort (
    .in_a  (raw_q[0]),
    .in_b  (raw_q[1]),
    .in_c  (raw_q[2]),
    .lo    (s_lo),
    .mid   (s_mid),
    .hi    (s_hi),
    .clash (s_clash)
  );

  assign scan_go = (state_q == ST_SORT) && !s_clash;
  assign accept  = wr_valid && wr_ready;

  sat_gen_store #(.DEPTH(MAX_CLAUSES), .DATA_W(CL_W)) i_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (accept),
    .wr_addr   (count_q[IDX_W-1:0]),
    .wr_data   (cand_q),
    .scan_go   (scan_go),
    .scan_key  ({s_hi, s_mid, s_lo}),
    .fill      (count_q),
    .scan_hit  (scan_hit),
    .scan_miss (scan_miss)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      m_q     <= '0;
      two_n_q <= '0;
      mask_q  <= '0;
      count_q <= '0;
      slot_q  <= '0;
      cand_q  <= '0;
      for (int i = 0; i < 3; i++) raw_q[i] <= '0;
    end else begin
      case (state_q)
        ST_IDLE, ST_DONE: begin
          if (take_start) begin
            m_q     <= m_clamped;
            two_n_q <= cfg_two_n;
            mask_q  <= mask_next;
            count_q <= '0;
            slot_q  <= '0;
            state_q <= (m_clamped == '0) ? ST_DONE : ST_DRAW;
          end
        end
        ST_DRAW: begin
          if (draw_ok) begin
            raw_q[slot_q] <= draw;
            if (slot_q == 2'd2) state_q <= ST_SORT;
            else                slot_q  <= slot_q + 2'd1;
          end
        end
        ST_SORT: begin
          cand_q <= {s_hi, s_mid, s_lo};
          slot_q <= '0;
          state_q <= s_clash ? ST_DRAW : ST_SCAN;
        end
        ST_SCAN: begin
          if (scan_hit)       state_q <= ST_DRAW;
          else if (scan_miss) state_q <= ST_EMIT;
        end
        ST_EMIT: begin
          if (wr_ready) begin
            count_q <= count_q + 1'b1;
            state_q <= (count_q + 1'b1 == m_q) ? ST_DONE : ST_DRAW;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign wr_valid = (state_q == ST_EMIT);
  assign done     = (state_q == ST_DONE);
  assign wr_index = count_q[IDX_W-1:0];
  assign wr_lit0  = cand_q[LIT_W-1:0];
  assign wr_lit1  = cand_q[2*LIT_W-1:LIT_W];
  assign wr_lit2  = cand_q[3*LIT_W-1:2*LIT_W];

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_index) && $stable(wr_lit0)
      && $stable(wr_lit1) && $stable(wr_lit2))) else $error("payload moved in stall"); // R6
  AST_LIT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_lit0 < wr_lit1) && (wr_lit1 < wr_lit2)) else $error("literals unsorted"); // R2
  AST_LIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (TWO_W'(wr_lit2) < two_n_q)) else $error("literal out of range"); // R2
  AST_NO_COMPLEMENT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_lit0[LIT_W-1:1] != wr_lit1[LIT_W-1:1])
      && (wr_lit1[LIT_W-1:1] != wr_lit2[LIT_W-1:1])) else $error("complement pair"); // R3
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (CNT_W'(wr_index) + CNT_W'(1) == m_q)) |=> done) else $error("done late"); // R7
  AST_INDEX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (CNT_W'(wr_index) < m_q)) else $error("index beyond M"); // R5

endmodule

// File: tb/test_sat_gen_top.sv
module test_sat_gen_top;

  localparam int CW = 7, VW = 6, IW = 6, LW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [CW-1:0] cfg_clauses = '0;
  logic [VW-1:0] cfg_vars = '0;
  logic [31:0]   seed = '0;
  logic          wr_valid, wr_ready = 1'b0, done;
  logic [IW-1:0] wr_index;
  logic [LW-1:0] wr_lit0, wr_lit1, wr_lit2;

  int checks = 0, fails = 0;
  int c0 [64], c1 [64], c2 [64], nrec;
  int r0 [64], r1 [64], r2 [64];

  always #5 clk = ~clk;

  sat_gen_top i_sat_gen_top (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_clauses(cfg_clauses),
    .cfg_vars(cfg_vars), .seed(seed), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_index(wr_index), .wr_lit0(wr_lit0), .wr_lit1(wr_lit1), .wr_lit2(wr_lit2),
    .done(done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run_gen(input int m, input int n, input logic [31:0] sd,
                         input int mode, input bit poke);
    int expect_n, k;
    bit stalled;
    int p_idx, p0, p1, p2;
    expect_n = (m > 64) ? 64 : m;
    @(negedge clk);
    cfg_clauses = CW'(m); cfg_vars = VW'(n); seed = sd; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    nrec = 0;
    if (expect_n == 0) begin
      check(done == 1'b1, "R7", "done after M=0 start", int'(done), 1);
      return;
    end
    check(done == 1'b0, "R1", "done cleared by start", int'(done), 0);
    stalled = 1'b0;
    p_idx = 0; p0 = 0; p1 = 0; p2 = 0;
    for (k = 0; k < 60000; k++) begin
      bit rdy;
      case (mode)
        0: rdy = 1'b1;
        1: rdy = (k % 3) != 0;
        default: rdy = (k % 7) >= 4;
      endcase
      if (poke) start = (k == 40);
      if (stalled)
        check(wr_valid && wr_index == IW'(p_idx) && wr_lit0 == LW'(p0) &&
              wr_lit1 == LW'(p1) && wr_lit2 == LW'(p2), "R6", "stall hold index",
              int'(wr_index), p_idx);
      stalled = 1'b0;
      if (wr_valid && !rdy) begin
        stalled = 1'b1;
        p_idx = int'(wr_index); p0 = int'(wr_lit0); p1 = int'(wr_lit1); p2 = int'(wr_lit2);
      end
      if (wr_valid && rdy) begin
        check(int'(wr_index) == nrec, "R5", "write index", int'(wr_index), nrec);
        c0[nrec] = int'(wr_lit0); c1[nrec] = int'(wr_lit1); c2[nrec] = int'(wr_lit2);
        nrec++;
      end
      wr_ready = rdy;
      @(negedge clk);
      if (nrec == expect_n) break;
    end
    start = 1'b0;
    wr_ready = 1'b0;
    check(nrec == expect_n, "R5", "clause count", nrec, expect_n);
    check(done == 1'b1 && wr_valid == 1'b0, "R7", "done one cycle after last", int'(done), 1);
    repeat (3) @(negedge clk);
    check(done == 1'b1 && wr_valid == 1'b0, "R7", "done holds", int'(done), 1);
  endtask

  task automatic validate(input int n);
    for (int i = 0; i < nrec; i++) begin
      check(c0[i] < c1[i] && c1[i] < c2[i], "R2", "ascending literals", c0[i], c1[i]);
      check(c2[i] < 2 * n, "R2", "literal below 2N", c2[i], 2 * n - 1);
      check((c0[i] >> 1) != (c1[i] >> 1) && (c1[i] >> 1) != (c2[i] >> 1),
            "R3", "no complement pair", c1[i] >> 1, -1);
      for (int j = 0; j < i; j++)
        if (c0[i] == c0[j] && c1[i] == c1[j] && c2[i] == c2[j])
          check(1'b0, "R4", "duplicate clause index", i, j);
    end
  endtask

  initial begin
    #(200000 * 10);
    checks++; fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int full;
    repeat (3) @(negedge clk);
    check(done == 1'b0 && wr_valid == 1'b0, "R1", "reset outputs", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // exhaustive small instances: every valid clause must appear (R4)
    for (int n = 3; n <= 4; n++) begin
      full = 8 * n * (n - 1) * (n - 2) / 6;
      run_gen(full, n, 32'hACE1_0000 + n, n - 3, 1'b0);
      validate(n);
      check(nrec == full, "R4", "all valid clauses produced", nrec, full);
    end

    // default size, determinism (R8)
    run_gen(64, 14, 32'h1234_5678, 0, 1'b0);
    validate(14);
    for (int i = 0; i < 64; i++) begin r0[i] = c0[i]; r1[i] = c1[i]; r2[i] = c2[i]; end
    run_gen(64, 14, 32'h1234_5678, 2, 1'b0);
    for (int i = 0; i < 64; i++)
      check(r0[i] == c0[i] && r1[i] == c1[i] && r2[i] == c2[i], "R8", "same seed same clause",
            c0[i], r0[i]);

    // start pulse mid-run ignored (R9)
    run_gen(64, 12, 32'h0BAD_F00D, 1, 1'b1);
    validate(12);
    check(nrec == 64, "R9", "mid-run start ignored", nrec, 64);

    // zero seed still completes (R8)
    run_gen(20, 17, 32'h0, 0, 1'b0);
    validate(17);
    check(nrec == 20, "R8", "zero seed run", nrec, 20);

    // clamp to capacity (R5) and upper N
    run_gen(100, 21, 32'h7777_0001, 1, 1'b0);
    validate(21);

    // M = 0 (R7)
    run_gen(0, 14, 32'h5, 0, 1'b0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule